// File: doc/BRIEF.md
# Masked Register Insert Execution Unit

This block runs one fixed-point instruction: a masked bit insert. It decodes a 32-bit instruction word and checks the word against a single legal encoding. It reads three registers from a 32-entry, 32-bit register file: a source, a mask and the current target. It then writes back a merged value. For each bit position, the result takes the source bit where the mask bit is 1 and keeps the old target bit where the mask bit is 0.

When the record bit of the word is set, a 4-bit condition field is also updated. The field holds three sign flags for the result and a copy of an external summary-overflow flag. Any other instruction word is reported as illegal for one cycle and changes nothing.

A small control state machine tracks the outcome of the last cycle and uses three named states:
- ST_IDLE is the state after reset and after any cycle with no strobe.
- ST_WROTE is entered after a legal instruction is accepted.
- ST_TRAP is entered after an illegal word is seen.

Every cycle follows the same transition rule from any state:
- A strobe with a legal word goes to ST_WROTE.
- A strobe with any other word goes to ST_TRAP.
- No strobe goes back to ST_IDLE.

A preload write port and a debug read port give direct access to the register file. They are used to set up operands and to observe results.

Top module: `mask_insert_unit`

## Requirements
- R1: A word is legal only when instr[31:26] = 31 and instr[10:1] = 541. The fields are source index instr[25:21], target index instr[20:16], mask index instr[15:11] and record bit instr[0].
- R2: A legal instruction writes (src & mask) | (old_target & ~mask) into the target register.
- R3: All three operands are the register values held before the instruction, including when indices coincide (for example, target = source or target = mask).
- R4: The register write and any condition update take effect at the clock edge that samples the strobe. During the following cycle wr_en is 1, wr_addr is the target index and wr_data is the result.
- R5: With record bit 0, cond_out is unchanged.
- R6: With record bit 1, cond_out = {LT, GT, EQ, SO}, with LT in bit 3. Exactly one of LT, GT or EQ is set, from a signed compare of the result with zero. SO is the so_in value in the strobe cycle.
- R7: An illegal word makes illegal 1 for exactly the following cycle, with wr_en 0. No register and no condition bit changes.
- R8: Synchronous reset clears every register, cond_out, wr_en and illegal to zero.
- R9: A cycle without the strobe is followed by a cycle with wr_en 0 and illegal 0, and no state changes.
- R10: dbg_rdata shows the current contents of register dbg_raddr without a clock delay.
- R11: dbg_we writes dbg_wdata to register dbg_waddr at the clock edge, but the write is ignored in any cycle where instr_valid is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| instr_valid | input | 1 | Instruction strobe |
| instr | input | 32 | Instruction word |
| so_in | input | 1 | External summary-overflow flag |
| dbg_we | input | 1 | Preload write enable |
| dbg_waddr | input | 5 | Preload register index |
| dbg_wdata | input | 32 | Preload value |
| dbg_raddr | input | 5 | Debug read index |
| dbg_rdata | output | 32 | Debug read data |
| wr_en | output | 1 | Register written in the previous cycle |
| wr_addr | output | 5 | Index of the written register |
| wr_data | output | 32 | Value written |
| cond_out | output | 4 | Condition field {LT, GT, EQ, SO} |
| illegal | output | 1 | Illegal-instruction pulse |

## Verification
The two directed merges use alternating-bit operands with sparse masks. They show that the source and the old target are picked bit by bit, and not swapped or combined with OR.

Random operands and random indices cover the general merge. Repeated indices show whether the operands are read before the write. Results chosen to be zero, positive and negative separate the three sign flags, and random so_in values show that SO is copied. Words with a corrupted primary or extended opcode confirm that nothing changes, and a preload issued during a strobe confirms that the port yields.

// File: rtl/mir_pkg.sv
`timescale 1ns/1ps
package mir_pkg;
    localparam logic [5:0] OPC_PRIMARY = 6'd31;
    localparam logic [9:0] OPC_EXT     = 10'd541;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_WROTE = 2'd1,
        ST_TRAP  = 2'd2
    } mir_state_e;

    typedef struct packed {
        logic lt;
        logic gt;
        logic eq;
        logic so;
    } cond_t;

    typedef struct packed {
        logic [5:0] opc;
        logic [4:0] rs;
        logic [4:0] ra;
        logic [4:0] rb;
        logic [9:0] xo;
        logic       rc;
    } word_t;
endpackage

// File: rtl/mir_decode.sv
`timescale 1ns/1ps
module mir_decode
    import mir_pkg::*;
(
    input  logic [31:0] word,
    output logic        legal,
    output logic [4:0]  rs,
    output logic [4:0]  ra,
    output logic [4:0]  rb,
    output logic        rc
);
    word_t f;

    always_comb begin
        f     = word_t'(word);
        legal = (f.opc == OPC_PRIMARY) && (f.xo == OPC_EXT);
        rs    = f.rs;
        ra    = f.ra;
        rb    = f.rb;
        rc    = f.rc;
    end
endmodule

// File: rtl/mir_regfile.sv
`timescale 1ns/1ps
module mir_regfile #(
    parameter int XLEN  = 32,
    parameter int NREGS = 32,
    parameter int NRD   = 3,
    localparam int AW   = $clog2(NREGS)
) (
    input  logic                      clk,
    input  logic                      rst,
    input  logic                      we,
    input  logic [AW-1:0]             waddr,
    input  logic [XLEN-1:0]           wdata,
    input  logic                      pre_we,
    input  logic [AW-1:0]             pre_waddr,
    input  logic [XLEN-1:0]           pre_wdata,
    input  logic [NRD-1:0][AW-1:0]    raddr,
    output logic [NRD-1:0][XLEN-1:0]  rdata,
    input  logic [AW-1:0]             peek_addr,
    output logic [XLEN-1:0]           peek_data
);
    logic [XLEN-1:0] mem [NREGS];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < NREGS; i++) begin
                mem[i] <= '0;
            end
        end else if (we) begin
            mem[waddr] <= wdata;
        end else if (pre_we) begin
            mem[pre_waddr] <= pre_wdata;
        end
    end

    for (genvar p = 0; p < NRD; p++) begin : g_rd
        assign rdata[p] = mem[raddr[p]];
    end

    assign peek_data = mem[peek_addr];
endmodule

// File: rtl/mir_merge.sv
`timescale 1ns/1ps
module mir_merge
    import mir_pkg::*;
#(
    parameter int XLEN = 32
) (
    input  logic [XLEN-1:0] src,
    input  logic [XLEN-1:0] mask,
    input  logic [XLEN-1:0] old,
    input  logic            so,
    output logic [XLEN-1:0] result,
    output cond_t           cond
);
    always_comb begin
        result  = (src & mask) | (old & ~mask);
        cond.lt = result[XLEN-1];
        cond.eq = (result == '0);
        cond.gt = !result[XLEN-1] && (result != '0);
        cond.so = so;
    end
endmodule

// File: rtl/mask_insert_unit.sv
`timescale 1ns/1ps
module mask_insert_unit
    import mir_pkg::*;
#(
    parameter int XLEN  = 32,
    parameter int NREGS = 32,
    localparam int AW   = $clog2(NREGS)
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            instr_valid,
    input  logic [31:0]     instr,
    input  logic            so_in,
    input  logic            dbg_we,
    input  logic [AW-1:0]   dbg_waddr,
    input  logic [XLEN-1:0] dbg_wdata,
    input  logic [AW-1:0]   dbg_raddr,
    output logic [XLEN-1:0] dbg_rdata,
    output logic            wr_en,
    output logic [AW-1:0]   wr_addr,
    output logic [XLEN-1:0] wr_data,
    output logic [3:0]      cond_out,
    output logic            illegal
);
    localparam int NRD = 3;
    localparam int P_SRC  = 0;
    localparam int P_MASK = 1;
    localparam int P_TGT  = 2;

    logic                     dec_legal, dec_rc;
    logic [4:0]               dec_rs, dec_ra, dec_rb;
    logic [NRD-1:0][AW-1:0]   rd_addr;
    logic [NRD-1:0][XLEN-1:0] rd_data;
    logic [XLEN-1:0]          merged;
    cond_t                    new_cond;
    logic                     accept;

    mir_state_e      state, state_nxt;
    logic [AW-1:0]   addr_q;
    logic [XLEN-1:0] data_q;
    cond_t           cond_q;

    mir_decode u_dec (
        .word  (instr),
        .legal (dec_legal),
        .rs    (dec_rs),
        .ra    (dec_ra),
        .rb    (dec_rb),
        .rc    (dec_rc)
    );

    assign rd_addr[P_SRC]  = AW'(dec_rs);
    assign rd_addr[P_MASK] = AW'(dec_rb);
    assign rd_addr[P_TGT]  = AW'(dec_ra);
    assign accept          = instr_valid && dec_legal;

    mir_regfile #(.XLEN(XLEN), .NREGS(NREGS), .NRD(NRD)) u_rf (
        .clk       (clk),
        .rst       (rst),
        .we        (accept),
        .waddr     (AW'(dec_ra)),
        .wdata     (merged),
        .pre_we    (dbg_we && !instr_valid),
        .pre_waddr (dbg_waddr),
        .pre_wdata (dbg_wdata),
        .raddr     (rd_addr),
        .rdata     (rd_data),
        .peek_addr (dbg_raddr),
        .peek_data (dbg_rdata)
    );

    mir_merge #(.XLEN(XLEN)) u_merge (
        .src    (rd_data[P_SRC]),
        .mask   (rd_data[P_MASK]),
        .old    (rd_data[P_TGT]),
        .so     (so_in),
        .result (merged),
        .cond   (new_cond)
    );

    // next-state logic: every state follows the same outcome rule
    always_comb begin
        state_nxt = ST_IDLE;
        unique case (state)
            ST_IDLE, ST_WROTE, ST_TRAP: begin
                if (instr_valid) state_nxt = dec_legal ? ST_WROTE : ST_TRAP;
                else             state_nxt = ST_IDLE;
            end
            default: state_nxt = ST_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk) begin
        if (rst) state <= ST_IDLE;
        else     state <= state_nxt;
    end

    // result and condition registers
    always_ff @(posedge clk) begin
        if (rst) begin
            addr_q <= '0;
            data_q <= '0;
            cond_q <= '0;
        end else if (accept) begin
            addr_q <= AW'(dec_ra);
            data_q <= merged;
            if (dec_rc) cond_q <= new_cond;
        end
    end

    // outputs
    always_comb begin
        wr_en    = (state == ST_WROTE);
        illegal  = (state == ST_TRAP);
        wr_addr  = addr_q;
        wr_data  = data_q;
        cond_out = cond_q;
    end
endmodule

// File: rtl/mir_checker.sv
`timescale 1ns/1ps
module mir_checker #(
    parameter int XLEN = 32,
    parameter int AW   = 5
) (
    input logic            clk,
    input logic            rst,
    input logic            instr_valid,
    input logic            dec_legal,
    input logic            dec_rc,
    input logic [4:0]      dec_ra,
    input logic            so_in,
    input logic            wr_en,
    input logic [AW-1:0]   wr_addr,
    input logic [XLEN-1:0] wr_data,
    input logic [3:0]      cond_out,
    input logic            illegal
);
    // R4: accepted instruction reports its target one cycle later
    p_write_slot_r4: assert property (@(posedge clk) disable iff (rst)
        instr_valid && dec_legal |=> wr_en && !illegal && (wr_addr == AW'($past(dec_ra))));

    // R5: no record update leaves the condition field alone
    p_cond_hold_r5: assert property (@(posedge clk) disable iff (rst)
        !(instr_valid && dec_legal && dec_rc) |=> $stable(cond_out));

    // R6: one sign flag, SO copied, LT matches result sign
    p_cond_onehot_r6: assert property (@(posedge clk) disable iff (rst)
        instr_valid && dec_legal && dec_rc |=> ($countones(cond_out[3:1]) == 1)
            && (cond_out[0] == $past(so_in)) && (cond_out[3] == wr_data[XLEN-1]));

    // R7: illegal word gives a single illegal pulse and no write
    p_trap_pulse_r7: assert property (@(posedge clk) disable iff (rst)
        instr_valid && !dec_legal |=> illegal && !wr_en);

    // R7: write and trap never coincide
    p_trap_excl_r7: assert property (@(posedge clk) disable iff (rst)
        !(wr_en && illegal));

    // R9: quiet cycle produces no report
    p_quiet_r9: assert property (@(posedge clk) disable iff (rst)
        !instr_valid |=> !wr_en && !illegal);
endmodule

bind mask_insert_unit mir_checker #(.XLEN(XLEN), .AW(AW)) u_chk (
    .clk         (clk),
    .rst         (rst),
    .instr_valid (instr_valid),
    .dec_legal   (dec_legal),
    .dec_rc      (dec_rc),
    .dec_ra      (dec_ra),
    .so_in       (so_in),
    .wr_en       (wr_en),
    .wr_addr     (wr_addr),
    .wr_data     (wr_data),
    .cond_out    (cond_out),
    .illegal     (illegal)
);

// File: tb/mask_insert_unit_test.sv
`timescale 1ns/1ps
module mask_insert_unit_test;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        instr_valid = 1'b0;
    logic [31:0] instr = '0;
    logic        so_in = 1'b0;
    logic        dbg_we = 1'b0;
    logic [4:0]  dbg_waddr = '0;
    logic [31:0] dbg_wdata = '0;
    logic [4:0]  dbg_raddr = '0;
    logic [31:0] dbg_rdata;
    logic        wr_en;
    logic [4:0]  wr_addr;
    logic [31:0] wr_data;
    logic [3:0]  cond_out;
    logic        illegal;

    int n_chk = 0;
    int n_err = 0;
    logic [31:0] model [32];
    logic [3:0]  mcond = '0;

    always #2 clk = ~clk;   // 250 MHz

    mask_insert_unit uut (
        .clk(clk), .rst(rst), .instr_valid(instr_valid), .instr(instr), .so_in(so_in),
        .dbg_we(dbg_we), .dbg_waddr(dbg_waddr), .dbg_wdata(dbg_wdata),
        .dbg_raddr(dbg_raddr), .dbg_rdata(dbg_rdata),
        .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .cond_out(cond_out), .illegal(illegal)
    );

    task automatic check(input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    function automatic logic [31:0] merge_f(input logic [31:0] s, m, o);
        return (s & m) | (o & ~m);
    endfunction

    function automatic logic [3:0] cond_f(input logic [31:0] r, input logic so);
        return {$signed(r) < 0, $signed(r) > 0, r == 32'd0, so};
    endfunction

    function automatic logic [31:0] enc(input int rs, ra, rb, input logic rc);
        return {6'd31, rs[4:0], ra[4:0], rb[4:0], 10'd541, rc};
    endfunction

    task automatic load(input int idx, input logic [31:0] val);
        @(negedge clk);
        dbg_we = 1'b1; dbg_waddr = idx[4:0]; dbg_wdata = val;
        @(negedge clk);
        dbg_we = 1'b0;
        model[idx] = val;
    endtask

    task automatic peek(input string req, input int idx);
        dbg_raddr = idx[4:0];
        #1;
        check(req, $sformatf("reg %0d", idx), dbg_rdata, model[idx]);
    endtask

    task automatic run(input logic [31:0] w, input logic so, input string req);
        logic        legal = (w[31:26] == 6'd31) && (w[10:1] == 10'd541);
        int          rs = int'(w[25:21]);
        int          ra = int'(w[20:16]);
        int          rb = int'(w[15:11]);
        logic [31:0] res = merge_f(model[rs], model[rb], model[ra]);
        @(negedge clk);
        instr = w; so_in = so; instr_valid = 1'b1;
        @(negedge clk);
        instr_valid = 1'b0;
        if (legal) begin
            model[ra] = res;
            if (w[0]) mcond = cond_f(res, so);
        end
        check(req, "wr_en", {31'd0, wr_en}, {31'd0, legal});
        check(req, "illegal", {31'd0, illegal}, {31'd0, !legal});
        if (legal) begin
            check("R4", "wr_addr", {27'd0, wr_addr}, ra[31:0]);
            check(req, "wr_data", wr_data, res);
        end
        check(w[0] ? "R6" : "R5", "cond_out", {28'd0, cond_out}, {28'd0, mcond});
        peek(req, ra);
    endtask

    initial begin
        #(4 * 150000);
        n_chk++; n_err++;
        $display("FAIL watchdog: actual=timeout expected=completion");
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

    initial begin
        void'($urandom(32'd20240611));
        for (int i = 0; i < 32; i++) model[i] = '0;

        // R8: reset state
        repeat (3) @(negedge clk);
        rst = 1'b0;
        check("R8", "wr_en", {31'd0, wr_en}, 32'd0);
        check("R8", "illegal", {31'd0, illegal}, 32'd0);
        check("R8", "cond_out", {28'd0, cond_out}, 32'd0);
        peek("R8", 0); peek("R8", 17); peek("R10", 31);

        // R2: directed merges with alternating patterns
        load(6, 32'hAAAAAAAA); load(4, 32'h000F0F00); load(5, 32'h55555555);
        run(enc(5, 6, 4, 1'b0), 1'b1, "R2");
        check("R2", "example1", model[6], 32'hAAA5A5AA);
        load(6, 32'hAAAAAAAA); load(4, 32'h0A050F00);
        run(enc(5, 6, 4, 1'b1), 1'b1, "R2");
        check("R2", "example2", model[6], 32'hA0AFA5AA);
        check("R6", "negative cond", {28'd0, mcond}, 32'h9);

        // R6: zero and positive results
        load(1, 32'h0); load(2, 32'hFFFFFFFF); load(3, 32'h12345678);
        run(enc(1, 3, 2, 1'b1), 1'b0, "R6");
        check("R6", "zero cond", {28'd0, mcond}, 32'h2);
        load(1, 32'h00000001);
        run(enc(1, 3, 2, 1'b1), 1'b1, "R6");
        check("R6", "positive cond", {28'd0, mcond}, 32'h5);

        // R3: aliased operands use pre-instruction values
        load(7, 32'hF0F0F0F0); load(8, 32'h3C3C3C3C);
        run(enc(8, 7, 7, 1'b0), 1'b0, "R3");   // target == mask
        check("R3", "alias mask", model[7], 32'h30303030);
        load(9, 32'h0F0F0F0F); load(10, 32'hFF00FF00);
        run(enc(9, 9, 10, 1'b1), 1'b0, "R3");  // target == source
        check("R3", "alias src", model[9], 32'h0F0F0F0F);

        // R7 / R1: corrupted opcodes
        run({6'd30, 5'd1, 5'd3, 5'd2, 10'd541, 1'b1}, 1'b1, "R7");
        run({6'd31, 5'd1, 5'd3, 5'd2, 10'd540, 1'b1}, 1'b0, "R1");
        @(negedge clk);
        check("R7", "single pulse", {31'd0, illegal}, 32'd0);

        // R9: quiet cycles
        @(negedge clk);
        check("R9", "wr_en", {31'd0, wr_en}, 32'd0);
        check("R9", "cond_out", {28'd0, cond_out}, {28'd0, mcond});
        peek("R9", 3);

        // R11: preload ignored during a strobe
        @(negedge clk);
        instr = enc(1, 11, 2, 1'b0); instr_valid = 1'b1; so_in = 1'b0;
        dbg_we = 1'b1; dbg_waddr = 5'd12; dbg_wdata = 32'hDEADBEEF;
        model[11] = merge_f(model[1], model[2], model[11]);
        @(negedge clk);
        instr_valid = 1'b0; dbg_we = 1'b0;
        peek("R11", 12); peek("R11", 11);

        // R2 / R1: random traffic
        for (int i = 0; i < 32; i++) load(i, $urandom);
        for (int n = 0; n < 200; n++) begin
            int          rs = int'($urandom % 32);
            int          ra = int'($urandom % 32);
            int          rb = int'($urandom % 32);
            logic        rc = 1'($urandom);
            logic [31:0] w = enc(rs, ra, rb, rc);
            int          kind = int'($urandom % 8);
            if (kind == 0) w[31:26] = w[31:26] ^ 6'(1 + $urandom % 63);
            if (kind == 1) w[10:1]  = w[10:1] ^ 10'(1 + $urandom % 1023);
            run(w, 1'($urandom), (kind < 2) ? "R1" : "R2");
        end
        for (int i = 0; i < 32; i++) peek("R10", i);

        // R8: reset mid-run clears everything
        @(negedge clk); rst = 1'b1;
        @(negedge clk); rst = 1'b0;
        for (int i = 0; i < 32; i++) model[i] = '0;
        mcond = '0;
        check("R8", "cond after reset", {28'd0, cond_out}, 32'd0);
        for (int i = 0; i < 32; i++) peek("R8", i);

        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end
endmodule